// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of an interval timer. Every clock is one count tick. A control write picks one of six operating modes and chooses binary or four-digit decimal (BCD) counting. A later count write supplies the initial value N. Depending on the mode, the channel either interrupts once at the end of the count, forms a gate-started one-shot pulse, divides the clock by N, generates a square wave of period N, or emits a single one-clock strobe. The strobe can follow a software-loaded count or a gate edge.

The GATE input has a different role in each mode. In the event-counting modes a low level pauses counting. In the periodic modes a low level holds the count and forces the output high, and a rising edge reloads the count. In the triggered modes a rising edge starts or restarts the count. The current count value and a flag that marks a written-but-not-yet-loaded count are visible at the ports.

Top module: `interval_channel`

## Requirements
- R1: Mode codes 6 and 7 behave exactly like codes 2 and 3, because the top mode bit is dropped for those two codes.
- R2: While reset is asserted, OUT is high, the count output is 0 and the pending-count flag is 0.
- R3: The pending-count flag is 1 in the cycle after a count write. It returns to 0 when that value is transferred into the counter: one clock later in modes 0, 2, 3 and 4, and on the triggering GATE rising edge in modes 1 and 5.
- R4: Mode 0: OUT is low from the control write onward. With a count N, OUT goes high N clocks after the value is loaded and stays high until the next write.
- R5: Mode 0: while GATE is low the count holds its value.
- R6: Mode 1: a written count does not start on its own. A GATE rising edge loads it, and OUT is low for exactly N clocks starting at that edge.
- R7: Mode 1: a count written during a pulse does not alter that pulse. A GATE rising edge during a pulse reloads the counter and restarts the N-clock low time.
- R8: Mode 2: OUT has period N with exactly one low clock in each period.
- R9: Mode 3: OUT is a square wave of period N. For even N it is high N/2 and low N/2 clocks. For odd N it is high (N+1)/2 and low (N-1)/2 clocks.
- R10: Mode 4: exactly one low clock on OUT appears N clocks after the count is loaded, and OUT is high otherwise.
- R11: Mode 5: nothing happens until a GATE rising edge. After it, a single one-clock low strobe appears N clocks after that edge.
- R12: Modes 2 and 3: GATE low forces OUT high on the next clock and freezes the count. A GATE rising edge reloads N.
- R13: With BCD selected, each nibble is a decimal digit: 0x0100 decrements to 0x0099. A loaded value of 0 stands for the largest count, which is 10000 in BCD and 65536 in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; one tick per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_mode | input | 3 | Mode code 0..7 captured on a control write |
| ctrl_bcd | input | 1 | 1 selects BCD counting, 0 selects binary |
| cnt_wr | input | 1 | Initial-count write strobe |
| cnt_val | input | 16 | Initial count N |
| gate | input | 1 | GATE level |
| out | output | 1 | Channel output |
| count | output | 16 | Current counter value |
| null_cnt | output | 1 | A written count has not yet reached the counter |

## Verification
The embedded properties assume the following about the inputs. Every value written while BCD is selected consists of valid decimal digits. Periodic modes receive N of at least 2. In the triggered modes, a count write never falls on the same clock as a GATE rising edge. The stimulus writes only decimal-clean values in BCD runs and uses N between 2 and 13 in the periodic table. It also moves GATE only on clocks that carry no write strobe, so each property sees exactly the input conditions it was written for.

// File: rtl/ich_pkg.sv
package ich_pkg;

    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONE_SHOT  = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_e;

    // codes 6 and 7 lose their top bit and fold onto the periodic modes
    function automatic mode_e fold_mode(input logic [2:0] code);
        logic [2:0] m;
        m = code[1] ? {1'b0, code[1:0]} : code;
        return mode_e'(m);
    endfunction

endpackage

// File: rtl/ich_decrement.sv
module ich_decrement #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt_in,
    input  logic             bcd,
    input  logic             by_two,
    output logic [WIDTH-1:0] cnt_out
);
    localparam int NDIG = WIDTH / 4;

    logic [NDIG:0]      brw;
    logic [WIDTH-1:0]   dec_bcd;
    logic [WIDTH-1:0]   dec_bin;

    assign brw[0] = 1'b0;

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        logic [3:0] dig;
        logic [3:0] take;
        assign dig = cnt_in[4*i +: 4];
        if (i == 0) begin : g_low
            assign take = by_two ? 4'd2 : 4'd1;
        end else begin : g_high
            assign take = {3'b000, brw[i]};
        end
        assign brw[i+1] = (dig < take);
        assign dec_bcd[4*i +: 4] = brw[i+1] ? 4'(dig + 4'd10 - take) : 4'(dig - take);
    end

    assign dec_bin = cnt_in - (by_two ? WIDTH'(2) : WIDTH'(1));
    assign cnt_out = bcd ? dec_bcd : dec_bin;

endmodule

// File: rtl/ich_gate_edge.sv
module ich_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign rise = gate & ~gate_q;

endmodule

// File: rtl/interval_channel.sv
module interval_channel #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [2:0]       ctrl_mode,
    input  logic             ctrl_bcd,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] cnt_val,
    input  logic             gate,
    output logic             out,
    output logic [WIDTH-1:0] count,
    output logic             null_cnt
);
    import ich_pkg::*;

    localparam int NDIG = WIDTH / 4;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    localparam logic [WIDTH-1:0] TWO = WIDTH'(2);

    typedef struct packed {
        mode_e            mode;
        logic             bcd;
        logic [WIDTH-1:0] init;
        logic [WIDTH-1:0] cnt;
        logic             pend;   // written count not yet in the counter
        logic             have;   // a count exists since the last control write
        logic             run;
        logic             done;
        logic             odd;
        logic             out;
    } chan_t;

    chan_t st_d, st_q;

    logic             gate_rise;
    logic [WIDTH-1:0] dec_val;
    logic             trig_mode, periodic, dec_en, load_now, sq_term;
    logic [WIDTH-1:0] even_init;

    ich_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    ich_decrement #(.WIDTH(WIDTH)) u_dec (
        .cnt_in  (st_q.cnt),
        .bcd     (st_q.bcd),
        .by_two  (st_q.mode == M_SQUARE),
        .cnt_out (dec_val)
    );

    always_comb begin
        st_d      = st_q;
        trig_mode = (st_q.mode == M_ONE_SHOT) || (st_q.mode == M_HW_STROBE);
        periodic  = (st_q.mode == M_RATE) || (st_q.mode == M_SQUARE);
        dec_en    = st_q.run && (trig_mode || gate);
        even_init = {st_q.init[WIDTH-1:1], 1'b0};
        sq_term   = (st_q.out && st_q.odd) ? (st_q.cnt == '0) : (st_q.cnt == TWO);

        unique case (st_q.mode)
            M_TC_INT, M_SW_STROBE: load_now = st_q.pend;
            M_RATE, M_SQUARE:      load_now = st_q.have && ((st_q.pend && !st_q.run) || gate_rise);
            default:               load_now = st_q.have && gate_rise;
        endcase

        // strobe modes idle high; a strobe lasts one clock
        if (st_q.mode == M_SW_STROBE || st_q.mode == M_HW_STROBE) st_d.out = 1'b1;

        if (load_now) begin
            st_d.cnt  = (st_q.mode == M_SQUARE) ? even_init : st_q.init;
            st_d.odd  = st_q.init[0];
            st_d.run  = 1'b1;
            st_d.pend = 1'b0;
            st_d.done = 1'b0;
            st_d.out  = !((st_q.mode == M_TC_INT) || (st_q.mode == M_ONE_SHOT));
        end else if (dec_en) begin
            unique case (st_q.mode)
                M_TC_INT, M_ONE_SHOT: begin
                    st_d.cnt = dec_val;
                    if (st_q.cnt == ONE && !st_q.done) begin
                        st_d.out  = 1'b1;
                        st_d.done = 1'b1;
                    end
                end
                M_SW_STROBE, M_HW_STROBE: begin
                    st_d.cnt = dec_val;
                    if (st_q.cnt == ONE && !st_q.done) begin
                        st_d.out  = 1'b0;
                        st_d.done = 1'b1;
                    end
                end
                M_RATE: begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt  = st_q.init;
                        st_d.pend = 1'b0;
                        st_d.out  = 1'b1;
                    end else begin
                        st_d.cnt = dec_val;
                        st_d.out = (st_q.cnt != TWO);
                    end
                end
                default: begin
                    if (sq_term) begin
                        st_d.cnt  = even_init;
                        st_d.odd  = st_q.init[0];
                        st_d.pend = 1'b0;
                        st_d.out  = !st_q.out;
                    end else begin
                        st_d.cnt = dec_val;
                    end
                end
            endcase
        end

        if (periodic && !gate) st_d.out = 1'b1;

        if (cnt_wr) begin
            st_d.init = cnt_val;
            st_d.pend = 1'b1;
            st_d.have = 1'b1;
            if (st_q.mode == M_TC_INT) st_d.out = 1'b0;
        end

        if (ctrl_wr) begin
            st_d.mode = fold_mode(ctrl_mode);
            st_d.bcd  = ctrl_bcd;
            st_d.run  = 1'b0;
            st_d.have = 1'b0;
            st_d.pend = 1'b0;
            st_d.done = 1'b0;
            st_d.out  = (fold_mode(ctrl_mode) != M_TC_INT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= M_TC_INT;
            st_q.out  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out      = st_q.out;
    assign count    = st_q.cnt;
    assign null_cnt = st_q.pend;

    // ---------------- embedded properties ----------------
    logic bcd_clean;
    always_comb begin
        bcd_clean = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (st_q.cnt[4*i +: 4] > 4'd9) bcd_clean = 1'b0;
        end
    end

    p_pend_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ctrl_wr) |=> null_cnt);

    p_tc_low_until_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TC_INT && st_q.run && !st_q.done) |-> !out);

    p_tc_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TC_INT && st_q.run && !gate && !ctrl_wr && !cnt_wr && !st_q.pend)
        |=> $stable(count));

    p_rate_single_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RATE && !out && !ctrl_wr) |=> out);

    p_strobe_single_r10_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SW_STROBE || st_q.mode == M_HW_STROBE) && !out && !ctrl_wr) |=> out);

    p_gate_forces_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_RATE || st_q.mode == M_SQUARE) && !gate && !ctrl_wr) |=> out);

    p_decimal_digits_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bcd && st_q.run) |-> bcd_clean);

endmodule

// File: tb/test_interval_channel.sv
module test_interval_channel;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctrl_wr;
    logic [2:0]  ctrl_mode;
    logic        ctrl_bcd;
    logic        cnt_wr;
    logic [15:0] cnt_val;
    logic        gate;
    logic        out;
    logic [15:0] count;
    logic        null_cnt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // {mode code, bcd, N, high clocks, low clocks}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd2, 1'b0, 16'd3,     8'd2, 8'd1},
        {3'd2, 1'b0, 16'd5,     8'd4, 8'd1},
        {3'd6, 1'b0, 16'd4,     8'd3, 8'd1},
        {3'd2, 1'b0, 16'd2,     8'd1, 8'd1},
        {3'd3, 1'b0, 16'd4,     8'd2, 8'd2},
        {3'd3, 1'b0, 16'd5,     8'd3, 8'd2},
        {3'd7, 1'b0, 16'd6,     8'd3, 8'd3},
        {3'd3, 1'b0, 16'd2,     8'd1, 8'd1},
        {3'd2, 1'b1, 16'h0010,  8'd9, 8'd1},
        {3'd3, 1'b1, 16'h0013,  8'd7, 8'd6}
    };

    interval_channel i_interval_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_mode (ctrl_mode),
        .ctrl_bcd  (ctrl_bcd),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val),
        .gate      (gate),
        .out       (out),
        .count     (count),
        .null_cnt  (null_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [2:0] m, input logic b);
        ctrl_wr = 1'b1; ctrl_mode = m; ctrl_bcd = b;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_cnt(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_val = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    initial begin
        int n, hi, lo, first;
        logic [15:0] held;
        string tag;
        rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_mode = '0; ctrl_bcd = 1'b0;
        cnt_wr = 1'b0; cnt_val = '0; gate = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 out at reset", 32'(out), 32'd1);
        chk("R2 count at reset", 32'(count), 32'd0);
        chk("R2 null at reset", 32'(null_cnt), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // periodic table
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][35:33] >= 3'd6)  tag = "R1 folded mode";
            else if (VEC[v][32])        tag = "R13 decimal periodic";
            else if (VEC[v][35:33] == 3'd2) tag = "R8 rate";
            else                        tag = "R9 square";
            write_ctrl(VEC[v][35:33], VEC[v][32]);
            write_cnt(VEC[v][31:16]);
            n = 0;
            while (out !== 1'b1 && n < 100) begin n++; @(negedge clk); end
            n = 0;
            while (out !== 1'b0 && n < 100) begin n++; @(negedge clk); end
            lo = 0;
            while (out === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
            hi = 0;
            while (out === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
            chk({tag, " high clocks"}, 32'(hi), 32'(VEC[v][15:8]));
            chk({tag, " low clocks"},  32'(lo), 32'(VEC[v][7:0]));
        end

        // mode 0 timing and null flag
        gate = 1'b1;
        write_ctrl(3'd0, 1'b0);
        chk("R4 low after control write", 32'(out), 32'd0);
        write_cnt(16'd5);
        chk("R3 null set after write", 32'(null_cnt), 32'd1);
        @(negedge clk);
        chk("R3 null cleared on load", 32'(null_cnt), 32'd0);
        chk("R4 loaded count", 32'(count), 32'd5);
        repeat (4) @(negedge clk);
        chk("R4 still low before zero", 32'(out), 32'd0);
        @(negedge clk);
        chk("R4 high at zero", 32'(out), 32'd1);
        repeat (3) @(negedge clk);
        chk("R4 stays high", 32'(out), 32'd1);

        // mode 0 gate pause
        write_cnt(16'd5);
        @(negedge clk);
        gate = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 count held with gate low", 32'(count), 32'd5);
        chk("R5 out still low", 32'(out), 32'd0);
        gate = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 resumes to zero", 32'(out), 32'd1);

        // mode 1 one-shot
        gate = 1'b0;
        write_ctrl(3'd1, 1'b0);
        write_cnt(16'd3);
        repeat (3) @(negedge clk);
        chk("R6 no start without trigger", 32'(out), 32'd1);
        chk("R3 null waits for trigger", 32'(null_cnt), 32'd1);
        gate = 1'b1;
        @(negedge clk);
        chk("R3 null cleared by trigger", 32'(null_cnt), 32'd0);
        n = 0;
        while (out === 1'b0 && n < 50) begin n++; @(negedge clk); end
        chk("R6 pulse length", 32'(n), 32'd3);

        // mode 1 new count mid-pulse without trigger
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        write_cnt(16'd6);
        n = 0;
        while (out === 1'b0 && n < 50) begin n++; @(negedge clk); end
        chk("R7 pulse unaffected by write", 32'(n), 32'd2);

        // mode 1 retrigger mid-pulse
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        chk("R7 retrigger reloads", 32'(count), 32'd6);
        n = 0;
        while (out === 1'b0 && n < 50) begin n++; @(negedge clk); end
        chk("R7 retriggered pulse length", 32'(n), 32'd6);

        // mode 4 software strobe
        gate = 1'b1;
        write_ctrl(3'd4, 1'b0);
        write_cnt(16'd3);
        @(negedge clk);
        lo = 0; first = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (out === 1'b0) begin lo++; if (first == 0) first = k; end
        end
        chk("R10 single strobe", 32'(lo), 32'd1);
        chk("R10 strobe position", 32'(first), 32'd3);

        // mode 5 hardware strobe
        gate = 1'b0;
        write_ctrl(3'd5, 1'b0);
        write_cnt(16'd2);
        lo = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (out === 1'b0) lo++;
        end
        chk("R11 idle before gate edge", 32'(lo), 32'd0);
        gate = 1'b1;
        lo = 0; first = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (out === 1'b0) begin lo++; if (first == 0) first = k; end
        end
        chk("R11 single strobe", 32'(lo), 32'd1);
        chk("R11 strobe position", 32'(first), 32'd3);

        // periodic gate behaviour
        write_ctrl(3'd2, 1'b0);
        write_cnt(16'd6);
        repeat (3) @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        chk("R12 gate low forces high", 32'(out), 32'd1);
        held = count;
        @(negedge clk);
        chk("R12 count frozen", 32'(count), 32'(held));
        gate = 1'b1;
        @(negedge clk);
        chk("R12 rising gate reloads", 32'(count), 32'd6);

        // decimal stepping and maximum count
        write_ctrl(3'd0, 1'b1);
        write_cnt(16'h0100);
        @(negedge clk);
        @(negedge clk);
        chk("R13 decimal borrow", 32'(count), 32'h0099);
        write_cnt(16'h0000);
        @(negedge clk);
        n = 0;
        while (out === 1'b0 && n < 12000) begin @(negedge clk); n++; end
        chk("R13 zero means 10000", 32'(n), 32'd10000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule